// File: doc/BRIEF.md
# Transmit Frame Length and Underrun Guard

This block sits on the byte stream that a transmit DMA engine pushes into the transmit data FIFO. Every byte that is accepted is counted against a programmable length limit. A frame that reaches the limit is cut short on that byte and marked so that the CRC stage appends a corrupted checksum. The length error is then treated as a sign of a damaged descriptor queue, so the block stops all further DMA traffic until software restarts it.

The block also watches for the source running dry partway through a frame while the FIFO side is still asking for data. That is an underrun. What happens next depends on a control bit. If the bit is set, the block halts the same way as for a length error. If it is clear, the block writes an underrun status for the frame, drops the rest of that frame as it arrives, and carries on with the next frame. A frame that ends normally gets a success status.

Both stream sides use valid/ready. A byte moves when valid and ready are both high on the same rising edge. Back-pressure from the FIFO side passes straight through to the source side while the block is running. While the block is halted, no byte moves. While it is discarding the rest of a frame, the source side is always ready and nothing is presented downstream. Downstream valid never depends on downstream ready.

Top module: `txg_frame_guard`

## Requirements
- R1: While running, `m_valid` equals `s_valid`, `s_ready` equals `m_ready`, and `m_data` and `m_last` carry `s_data` and `s_last`. A byte with `m_ready` low is neither accepted nor counted.
- R2: The byte count covers only accepted bytes. It restarts from zero at every frame boundary, so back-to-back frames are each judged on their own length.
- R3: If a byte would bring the count of the current frame to a value greater than or equal to `max_len`, that byte goes out with `m_last`=1 and `m_bad_crc`=1. On the next cycle `len_err`=1 and `dma_halt`=1. A frame of `max_len`-1 bytes passes with `m_bad_crc`=0.
- R4: While `dma_halt`=1, both `s_ready` and `m_valid` are 0.
- R5: An underrun is a cycle in which at least one byte of the current frame has been accepted and its last byte has not, `m_ready`=1, and `s_valid`=0. Outside a frame, and while `m_ready`=0, no underrun is raised.
- R6: On an underrun with `underrun_halt_en`=1, the next cycle shows `underrun_err`=1 and `dma_halt`=1, and no status strobe is issued.
- R7: On an underrun with `underrun_halt_en`=0, the next cycle shows a one-cycle `stat_we` with `stat_code`=2'b10 and no halt. The remaining bytes of that frame are then taken with `s_ready`=1 and `m_valid`=0, up to and including the byte with `s_last`=1. The frame after that is forwarded normally.
- R8: A frame whose last byte is accepted without a length error gives `stat_we`=1 with `stat_code`=2'b01 on the following cycle.
- R9: A frame ended by a length error gets no status strobe. Once halted, the block reports no underrun.
- R10: A `restart` pulse while halted clears `dma_halt`, `len_err` and `underrun_err` by the next cycle, and forwarding resumes. That is the only way out of the halted state.
- R11: After reset, `dma_halt`, `len_err`, `underrun_err` and `stat_we` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| max_len | input | LEN_W | Frame length limit in bytes |
| underrun_halt_en | input | 1 | 1: an underrun halts DMA; 0: status is written and the block moves on |
| restart | input | 1 | One-cycle pulse that leaves the halted state |
| s_valid | input | 1 | Source byte valid |
| s_ready | output | 1 | Source byte accepted |
| s_data | input | DATA_W | Source byte |
| s_last | input | 1 | Source byte ends the frame |
| m_valid | output | 1 | Byte valid towards the FIFO |
| m_ready | input | 1 | FIFO can take a byte |
| m_data | output | DATA_W | Byte towards the FIFO |
| m_last | output | 1 | Byte ends the frame (normal end or truncation) |
| m_bad_crc | output | 1 | Frame is truncated and the CRC stage must corrupt its checksum |
| dma_halt | output | 1 | Transmit DMA is stopped |
| len_err | output | 1 | Sticky length error flag |
| underrun_err | output | 1 | Sticky underrun-halt flag |
| stat_we | output | 1 | One-cycle frame status write strobe |
| stat_code | output | 2 | Status code: 01 good frame, 10 underrun |

## Verification
A frame well under the limit confirms plain forwarding and the success status. Frames of `max_len`-1 and `max_len` bytes pin down the greater-or-equal boundary, so an off-by-one in the comparison shows up. Two short frames sent back to back, and a frame interrupted by a back-pressure stall, show whether the counter restarts per frame and whether it ignores bytes that were not accepted. Source gaps are driven with `m_ready` high and with it low, and with each setting of the halt bit. These separate a real underrun from an idle link, and the halting response from the skip-and-continue response. A restart then confirms that traffic resumes.

// File: rtl/txg_pkg.sv
package txg_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_SKIP = 2'd1,
    ST_HALT = 2'd2
  } txg_state_e;

  localparam logic [1:0] STAT_NONE     = 2'b00;
  localparam logic [1:0] STAT_OK       = 2'b01;
  localparam logic [1:0] STAT_UNDERRUN = 2'b10;
endpackage

// File: rtl/txg_len_counter.sv
module txg_len_counter #(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_i,
  input  logic             close_i,
  input  logic [LEN_W-1:0] max_len_i,
  output logic             at_limit_o,
  output logic             in_frame_o
);
  localparam int CW = LEN_W + 1;

  logic [LEN_W-1:0] cnt_q;
  logic [CW-1:0]    cnt_inc;

  // Count the current byte would reach if it were accepted now.
  assign cnt_inc    = {1'b0, cnt_q} + CW'(1);
  assign at_limit_o = (cnt_inc >= {1'b0, max_len_i});
  assign in_frame_o = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (close_i) cnt_q <= '0;
    else if (beat_i)  cnt_q <= cnt_inc[LEN_W-1:0];
  end

  // R2: a frame boundary or an abort always restarts the count
  assert_close_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    close_i |=> !in_frame_o);
  // R2: an accepted byte that does not close the frame leaves a frame open
  assert_beat_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_i && !close_i) |=> in_frame_o);
endmodule

// File: rtl/txg_stream_gate.sv
module txg_stream_gate
  import txg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  txg_state_e        state_i,
  input  logic              at_limit_i,
  input  logic              s_valid_i,
  output logic              s_ready_o,
  input  logic [DATA_W-1:0] s_data_i,
  input  logic              s_last_i,
  output logic              m_valid_o,
  input  logic              m_ready_i,
  output logic [DATA_W-1:0] m_data_o,
  output logic              m_last_o,
  output logic              m_bad_crc_o,
  output logic              fwd_beat_o,
  output logic              drop_beat_o
);
  always_comb begin
    s_ready_o   = 1'b0;
    m_valid_o   = 1'b0;
    m_last_o    = 1'b0;
    m_bad_crc_o = 1'b0;
    unique case (state_i)
      ST_RUN: begin
        s_ready_o   = m_ready_i;
        m_valid_o   = s_valid_i;
        // Truncate on the byte that reaches the limit.
        m_last_o    = s_last_i | at_limit_i;
        m_bad_crc_o = at_limit_i;
      end
      ST_SKIP: s_ready_o = 1'b1;
      default: ;
    endcase
  end

  assign m_data_o    = s_data_i;
  assign fwd_beat_o  = (state_i == ST_RUN)  && s_valid_i && m_ready_i;
  assign drop_beat_o = (state_i == ST_SKIP) && s_valid_i;
endmodule

// File: rtl/txg_ctrl.sv
module txg_ctrl
  import txg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fwd_beat_i,
  input  logic       drop_beat_i,
  input  logic       s_last_i,
  input  logic       s_valid_i,
  input  logic       m_ready_i,
  input  logic       at_limit_i,
  input  logic       in_frame_i,
  input  logic       uh_en_i,
  input  logic       restart_i,
  output txg_state_e state_o,
  output logic       abort_o,
  output logic       halt_o,
  output logic       len_err_o,
  output logic       und_err_o,
  output logic       stat_we_o,
  output logic [1:0] stat_code_o
);
  txg_state_e state_q, state_d;
  logic       len_d, und_d, we_d;
  logic [1:0] code_d;
  logic       und_ev;

  // The source is dry mid-frame while the FIFO side wants data.
  assign und_ev  = (state_q == ST_RUN) && in_frame_i && m_ready_i && !s_valid_i;
  assign abort_o = und_ev;

  always_comb begin
    state_d = state_q;
    len_d   = len_err_o;
    und_d   = und_err_o;
    we_d    = 1'b0;
    code_d  = STAT_NONE;
    unique case (state_q)
      ST_RUN: begin
        if (fwd_beat_i && at_limit_i) begin
          state_d = ST_HALT;
          len_d   = 1'b1;
        end else if (und_ev) begin
          if (uh_en_i) begin
            state_d = ST_HALT;
            und_d   = 1'b1;
          end else begin
            state_d = ST_SKIP;
            we_d    = 1'b1;
            code_d  = STAT_UNDERRUN;
          end
        end else if (fwd_beat_i && s_last_i) begin
          we_d   = 1'b1;
          code_d = STAT_OK;
        end
      end
      ST_SKIP: begin
        if (drop_beat_i && s_last_i) state_d = ST_RUN;
      end
      ST_HALT: begin
        if (restart_i) begin
          state_d = ST_RUN;
          len_d   = 1'b0;
          und_d   = 1'b0;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_RUN;
      len_err_o   <= 1'b0;
      und_err_o   <= 1'b0;
      stat_we_o   <= 1'b0;
      stat_code_o <= STAT_NONE;
    end else begin
      state_q     <= state_d;
      len_err_o   <= len_d;
      und_err_o   <= und_d;
      stat_we_o   <= we_d;
      stat_code_o <= code_d;
    end
  end

  assign state_o = state_q;
  assign halt_o  = (state_q == ST_HALT);

  // R3 and R9: a length hit halts DMA and writes no status
  assert_len_halts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && fwd_beat_i && at_limit_i) |=> (halt_o && len_err_o && !stat_we_o));
  // R4: no byte moves while halted
  assert_halt_no_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |-> (!fwd_beat_i && !drop_beat_i));
  // R6: an underrun with halt enabled stops DMA silently
  assert_und_halt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (und_ev && uh_en_i) |=> (halt_o && und_err_o && !stat_we_o));
  // R7: an underrun with halt disabled writes underrun status and skips
  assert_und_skip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (und_ev && !uh_en_i) |=> (!halt_o && stat_we_o && stat_code_o == STAT_UNDERRUN));
  // R8: a clean end of frame writes success status
  assert_good_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && fwd_beat_i && s_last_i && !at_limit_i) |=> (stat_we_o && stat_code_o == STAT_OK));
  // R10: restart leaves the halted state and clears the flags
  assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_o && restart_i) |=> (!halt_o && !len_err_o && !und_err_o));
endmodule

// File: rtl/txg_frame_guard.sv
module txg_frame_guard
  import txg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  max_len,
  input  logic              underrun_halt_en,
  input  logic              restart,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_last,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_last,
  output logic              m_bad_crc,
  output logic              dma_halt,
  output logic              len_err,
  output logic              underrun_err,
  output logic              stat_we,
  output logic [1:0]        stat_code
);
  txg_state_e state;
  logic at_limit, in_frame, fwd_beat, drop_beat, abort, close;

  // A frame closes on its last byte, on truncation, on an underrun abort or on restart.
  assign close = (fwd_beat && (s_last || at_limit)) || abort || restart;

  txg_len_counter #(.LEN_W(LEN_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat_i     (fwd_beat),
    .close_i    (close),
    .max_len_i  (max_len),
    .at_limit_o (at_limit),
    .in_frame_o (in_frame)
  );

  txg_stream_gate #(.DATA_W(DATA_W)) u_gate (
    .state_i     (state),
    .at_limit_i  (at_limit),
    .s_valid_i   (s_valid),
    .s_ready_o   (s_ready),
    .s_data_i    (s_data),
    .s_last_i    (s_last),
    .m_valid_o   (m_valid),
    .m_ready_i   (m_ready),
    .m_data_o    (m_data),
    .m_last_o    (m_last),
    .m_bad_crc_o (m_bad_crc),
    .fwd_beat_o  (fwd_beat),
    .drop_beat_o (drop_beat)
  );

  txg_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .fwd_beat_i  (fwd_beat),
    .drop_beat_i (drop_beat),
    .s_last_i    (s_last),
    .s_valid_i   (s_valid),
    .m_ready_i   (m_ready),
    .at_limit_i  (at_limit),
    .in_frame_i  (in_frame),
    .uh_en_i     (underrun_halt_en),
    .restart_i   (restart),
    .state_o     (state),
    .abort_o     (abort),
    .halt_o      (dma_halt),
    .len_err_o   (len_err),
    .und_err_o   (underrun_err),
    .stat_we_o   (stat_we),
    .stat_code_o (stat_code)
  );
endmodule

// File: tb/tb_txg_frame_guard.sv
module tb_txg_frame_guard;
  localparam int DATA_W = 8;
  localparam int LEN_W  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LEN_W-1:0] max_len = 12'd10;
  logic underrun_halt_en = 1'b0;
  logic restart = 1'b0;
  logic s_valid = 1'b0, s_last = 1'b0, m_ready = 1'b0;
  logic [DATA_W-1:0] s_data = '0;
  logic s_ready, m_valid, m_last, m_bad_crc, dma_halt, len_err, underrun_err, stat_we;
  logic [DATA_W-1:0] m_data;
  logic [1:0] stat_code;

  int vectors = 0;
  int miscompares = 0;

  always #10 clk = ~clk;

  txg_frame_guard #(.DATA_W(DATA_W), .LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .max_len(max_len), .underrun_halt_en(underrun_halt_en),
    .restart(restart), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_last(s_last), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_last(m_last), .m_bad_crc(m_bad_crc), .dma_halt(dma_halt), .len_err(len_err),
    .underrun_err(underrun_err), .stat_we(stat_we), .stat_code(stat_code)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Drive just after a rising edge, return at the next falling edge.
  // Outputs from the combinational paths reflect these inputs.
  // Registered outputs reflect the edge that ended the previous step.
  task automatic step(input logic v, input logic [7:0] d, input logic l, input logic mr);
    @(posedge clk); #2;
    s_valid = v; s_data = d; s_last = l; m_ready = mr;
    @(negedge clk);
  endtask

  task automatic do_restart();
    @(posedge clk); #2;
    s_valid = 0; m_ready = 0; restart = 1;
    @(posedge clk); #2;
    restart = 0;
    @(negedge clk);
  endtask

  task automatic fwd(input string req, input logic [7:0] d, input logic l, input logic exp_bad);
    step(1, d, l, 1);
    chk(req, "m_valid", m_valid, 1);
    chk(req, "s_ready", s_ready, 1);
    chk(req, "m_data", m_data, d);
    chk(req, "m_last", m_last, l | exp_bad);
    chk(req, "m_bad_crc", m_bad_crc, exp_bad);
  endtask

  task automatic t_reset();
    chk("R11", "dma_halt", dma_halt, 0);
    chk("R11", "len_err", len_err, 0);
    chk("R11", "underrun_err", underrun_err, 0);
    chk("R11", "stat_we", stat_we, 0);
    // R5: source idle outside a frame with FIFO ready is not an underrun
    step(0, 0, 0, 1);
    step(0, 0, 0, 1);
    step(0, 0, 0, 0);
    chk("R5", "stat_we idle", stat_we, 0);
    chk("R5", "dma_halt idle", dma_halt, 0);
  endtask

  task automatic t_good();
    max_len = 12'd10;
    fwd("R1", 8'h11, 0, 0);
    fwd("R1", 8'h22, 0, 0);
    fwd("R1", 8'h33, 0, 0);
    fwd("R1", 8'h44, 0, 0);
    fwd("R1", 8'h55, 1, 0);
    step(0, 0, 0, 0);
    chk("R8", "stat_we", stat_we, 1);
    chk("R8", "stat_code", stat_code, 2'b01);
    step(0, 0, 0, 0);
    chk("R8", "stat_we one cycle", stat_we, 0);
  endtask

  task automatic t_limit();
    max_len = 12'd4;
    fwd("R3", 8'h01, 0, 0);
    fwd("R3", 8'h02, 0, 0);
    fwd("R3", 8'h03, 0, 0);
    fwd("R3", 8'h04, 0, 1);
    step(0, 0, 0, 0);
    chk("R3", "dma_halt", dma_halt, 1);
    chk("R3", "len_err", len_err, 1);
    chk("R9", "stat_we on length error", stat_we, 0);
    step(1, 8'h05, 0, 1);
    chk("R4", "s_ready halted", s_ready, 0);
    chk("R4", "m_valid halted", m_valid, 0);
    step(0, 0, 0, 1);
    step(0, 0, 0, 0);
    chk("R9", "underrun_err while halted", underrun_err, 0);
    chk("R9", "stat_we while halted", stat_we, 0);
    chk("R10", "still halted without restart", dma_halt, 1);
    do_restart();
    chk("R10", "dma_halt cleared", dma_halt, 0);
    chk("R10", "len_err cleared", len_err, 0);
    max_len = 12'd10;
    fwd("R10", 8'h77, 1, 0);
    step(0, 0, 0, 0);
    chk("R10", "resumed stat_code", stat_code, 2'b01);
  endtask

  task automatic t_below();
    max_len = 12'd4;
    fwd("R3", 8'hA1, 0, 0);
    fwd("R3", 8'hA2, 0, 0);
    fwd("R3", 8'hA3, 1, 0);
    step(0, 0, 0, 0);
    chk("R3", "no halt at max_len-1", dma_halt, 0);
    chk("R8", "stat_code", stat_code, 2'b01);
  endtask

  task automatic t_perframe();
    max_len = 12'd4;
    fwd("R2", 8'hB1, 0, 0);
    fwd("R2", 8'hB2, 0, 0);
    fwd("R2", 8'hB3, 1, 0);
    fwd("R2", 8'hC1, 0, 0);
    fwd("R2", 8'hC2, 0, 0);
    fwd("R2", 8'hC3, 1, 0);
    step(0, 0, 0, 0);
    chk("R2", "second frame stat_code", stat_code, 2'b01);
    chk("R2", "no halt", dma_halt, 0);
  endtask

  task automatic t_stall();
    max_len = 12'd4;
    fwd("R2", 8'hD1, 0, 0);
    step(1, 8'hD2, 0, 0);
    chk("R1", "s_ready under back-pressure", s_ready, 0);
    chk("R1", "m_valid under back-pressure", m_valid, 1);
    step(0, 0, 0, 0);
    fwd("R2", 8'hD2, 0, 0);
    fwd("R2", 8'hD3, 1, 0);
    step(0, 0, 0, 0);
    chk("R5", "no underrun with m_ready low", underrun_err, 0);
    chk("R2", "stalled frame status", stat_code, 2'b01);
    chk("R2", "stalled frame no halt", dma_halt, 0);
  endtask

  task automatic t_und_skip();
    max_len = 12'd10;
    underrun_halt_en = 0;
    fwd("R7", 8'hE1, 0, 0);
    fwd("R7", 8'hE2, 0, 0);
    step(0, 0, 0, 1);
    step(0, 0, 0, 0);
    chk("R7", "stat_we", stat_we, 1);
    chk("R7", "stat_code", stat_code, 2'b10);
    chk("R7", "no halt", dma_halt, 0);
    step(1, 8'hE3, 0, 1);
    chk("R7", "skip m_valid", m_valid, 0);
    chk("R7", "skip s_ready", s_ready, 1);
    step(1, 8'hE4, 1, 0);
    chk("R7", "skip s_ready with m_ready low", s_ready, 1);
    chk("R7", "skip m_valid last", m_valid, 0);
    fwd("R7", 8'h99, 1, 0);
    step(0, 0, 0, 0);
    chk("R7", "next frame status", stat_code, 2'b01);
  endtask

  task automatic t_und_halt();
    max_len = 12'd10;
    underrun_halt_en = 1;
    fwd("R6", 8'hF1, 0, 0);
    step(0, 0, 0, 1);
    step(0, 0, 0, 0);
    chk("R6", "underrun_err", underrun_err, 1);
    chk("R6", "dma_halt", dma_halt, 1);
    chk("R6", "no stat_we", stat_we, 0);
    step(1, 8'hF2, 0, 1);
    chk("R4", "s_ready halted", s_ready, 0);
    do_restart();
    chk("R10", "underrun_err cleared", underrun_err, 0);
    chk("R10", "dma_halt cleared", dma_halt, 0);
    underrun_halt_en = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_good();
    t_limit();
    t_below();
    t_perframe();
    t_stall();
    t_und_skip();
    t_und_halt();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule